// File: doc/BRIEF.md
# DMA Address Hold Loop Generator

This block produces the byte addresses for both sides of a DMA copy, one address for reads and one for writes. On a start pulse each side loads its base address. Each advance pulse then moves both sides on by one byte. By default a side counts upward without limit. A side can instead be confined to a small repeating window, which lets it target a FIFO-like register region. In that case it walks base, base+1, up to base+N-1, and then returns to base.

Each side has its own window control in the mode word: a hold-enable bit and a two-bit field that holds log2 of the window size. This gives windows of 1, 2, 4 or 8 bytes. The two sides are set up independently. The mode is captured at the start pulse, so a transfer runs with one consistent configuration. The wrap is measured from the loaded base, so bases that are not aligned to the window work the same way as aligned ones. The block does not move data, parse descriptors or drive any bus.

Top module: `dma_addr_hold_gen`

## Requirements
- R1: After synchronous active-low reset both address outputs are zero.
- R2: A start pulse loads src_base_i and dst_base_i onto the outputs on the next clock edge and captures mode_i. If start and advance are high in the same cycle, start wins and the outputs show the bases.
- R3: A side whose hold bit is clear (mode bit 12 for source, mode bit 13 for destination) adds one to its address on each advance pulse.
- R4: When mode bit 12 is set, the source address cycles over N = 2^mode[15:14] bytes: base, base+1, up to base+N-1, then back to base.
- R5: When mode bit 13 is set, the destination address cycles over N = 2^mode[17:16] bytes in the same way.
- R6: A held side with a window field of 0 (window of one byte) stays at its base on every advance.
- R7: The source and destination settings are independent. One side may be held while the other counts linearly, and two held sides may use different windows.
- R8: The wrap is taken relative to the loaded base, not by masking low address bits. For example, base 0x1006 with a window of 4 gives 0x1006, 0x1007, 0x1008, 0x1009, 0x1006.
- R9: In a cycle with neither start nor advance, both addresses keep their values.
- R10: Changes to mode_i after the start pulse have no effect until the next start pulse.
- R11: A linear side wraps modulo 2^AW, so an all-ones address steps to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Load bases and capture mode |
| adv_i | input | 1 | Advance both addresses by one byte |
| mode_i | input | 6 (bits 17:12) | Hold slice of the mode word: bit 12 source hold, bit 13 destination hold, 15:14 source log2 window, 17:16 destination log2 window |
| src_base_i | input | AW | Source base address |
| dst_base_i | input | AW | Destination base address |
| src_addr_o | output | AW | Current source address |
| dst_addr_o | output | AW | Current destination address |

## Verification
The sequencer's assertions check several properties on every cycle for each side. A start loads the base. A linear side steps by exactly one. Addresses are stable when no strobe is present. A held address always equals the captured base plus an offset that stays inside the window, and a one-byte window never leaves its base. Other behaviours can only be shown by the bench's scenarios, because they span a whole run or two different runs. These are the exact wrap sequence for each window size, unaligned bases, independence of the two sides, mode changes that are ignored in the middle of a run, and the modulo-2^AW wrap of a linear side.

// File: rtl/addr_hold_pkg.sv
// Shared constants for the DMA address hold loop generator.
// Assumes the hold fields occupy bits 17:12 of the channel mode word.
package addr_hold_pkg;
    // Mode-word slice that carries the hold controls
    localparam int MODE_LSB    = 12;
    localparam int MODE_MSB    = 17;
    // Field positions inside the mode word (decoded by the sequencers)
    localparam int SRC_EN_BIT  = 12;
    localparam int DST_EN_BIT  = 13;
    localparam int SRC_LG_LSB  = 14;
    localparam int DST_LG_LSB  = 16;
    // Width of the log2 window field and of the in-window offset
    localparam int LG_W        = 2;
    localparam int OFF_W       = (1 << LG_W) - 1;
    localparam int NUM_SIDES   = 2;

    // Decoded hold configuration for one side
    typedef struct packed {
        logic             hold;
        logic [OFF_W-1:0] last_off;
    } hold_cfg_t;
endpackage

// File: rtl/hold_cfg_decode.sv
// Decodes one side's hold-enable bit and log2 window field into a hold flag
// and the last in-window offset (window size minus one).
// Assumes EN_BIT and LG_LSB lie inside the mode slice MODE_MSB:MODE_LSB.
module hold_cfg_decode
    import addr_hold_pkg::*;
#(
    parameter int EN_BIT = SRC_EN_BIT,
    parameter int LG_LSB = SRC_LG_LSB
) (
    input  logic [MODE_MSB:MODE_LSB] mode_i,
    output hold_cfg_t                cfg_o
);
    logic [LG_W-1:0] lg;

    // Extract the fields and form the last offset of the window
    always_comb begin
        lg             = mode_i[LG_LSB +: LG_W];
        cfg_o.hold     = mode_i[EN_BIT];
        cfg_o.last_off = OFF_W'((1 << lg) - 1);
    end
endmodule

// File: rtl/addr_hold_seq.sv
// Address sequencer for one side of a DMA copy.
// On start it captures base and config; on advance it steps by one byte,
// either linearly or around a window that begins at the captured base.
// Assumes start has priority over advance in the same cycle.
module addr_hold_seq
    import addr_hold_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start_i,
    input  logic      adv_i,
    input  logic [AW-1:0] base_i,
    input  hold_cfg_t cfg_i,
    output logic [AW-1:0] addr_o
);
    logic [AW-1:0]    base_q, addr_q, addr_d;
    logic [OFF_W-1:0] off_q, off_d;
    hold_cfg_t        cfg_q;

    // Next address and offset for an advance under the captured config
    always_comb begin
        addr_d = addr_q + AW'(1);
        off_d  = off_q + OFF_W'(1);
        if (cfg_q.hold && (off_q == cfg_q.last_off)) begin
            addr_d = base_q;
            off_d  = '0;
        end
    end

    // State update: reset, start load, or advance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            addr_q <= '0;
            off_q  <= '0;
            cfg_q  <= '0;
        end else if (start_i) begin
            base_q <= base_i;
            addr_q <= base_i;
            off_q  <= '0;
            cfg_q  <= cfg_i;
        end else if (adv_i) begin
            addr_q <= addr_d;
            off_q  <= off_d;
        end
    end

    assign addr_o = addr_q;

    AST_START_LOADS_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (addr_q == $past(base_i)));                               // R2
    AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i && adv_i && !cfg_q.hold) |=> (addr_q == $past(addr_q) + AW'(1))); // R3
    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i && !adv_i) |=> $stable(addr_q));                            // R9
    AST_OFF_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q.hold |-> (off_q <= cfg_q.last_off));                            // R4
    AST_WRAP_FROM_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q.hold |-> (addr_q == base_q + AW'(off_q)));                      // R8
    AST_SINGLE_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.hold && cfg_q.last_off == '0) |-> (addr_q == base_q));         // R6
endmodule

// File: rtl/dma_addr_hold_gen.sv
// Top of the DMA address hold loop generator: one decoder and one
// sequencer per side (source, destination), both sharing start/advance.
// Assumes mode_i is the bit 17:12 slice of the channel mode word.
module dma_addr_hold_gen
    import addr_hold_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_i,
    input  logic                    adv_i,
    input  logic [MODE_MSB:MODE_LSB] mode_i,
    input  logic [AW-1:0]           src_base_i,
    input  logic [AW-1:0]           dst_base_i,
    output logic [AW-1:0]           src_addr_o,
    output logic [AW-1:0]           dst_addr_o
);
    logic [AW-1:0] base_s [NUM_SIDES];
    logic [AW-1:0] addr_s [NUM_SIDES];
    hold_cfg_t     cfg_s  [NUM_SIDES];

    // Map the side-indexed arrays to the ports
    always_comb begin
        base_s[0]  = src_base_i;
        base_s[1]  = dst_base_i;
        src_addr_o = addr_s[0];
        dst_addr_o = addr_s[1];
    end

    for (genvar g = 0; g < NUM_SIDES; g++) begin : g_side
        localparam int EB = (g == 0) ? SRC_EN_BIT : DST_EN_BIT;
        localparam int LB = (g == 0) ? SRC_LG_LSB : DST_LG_LSB;

        hold_cfg_decode #(.EN_BIT(EB), .LG_LSB(LB)) u_dec (
            .mode_i (mode_i),
            .cfg_o  (cfg_s[g])
        );

        addr_hold_seq #(.AW(AW)) u_seq (
            .clk     (clk),
            .rst_n   (rst_n),
            .start_i (start_i),
            .adv_i   (adv_i),
            .base_i  (base_s[g]),
            .cfg_i   (cfg_s[g]),
            .addr_o  (addr_s[g])
        );
    end
endmodule

// File: tb/sim_dma_addr_hold_gen.sv
module sim_dma_addr_hold_gen;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          adv = 1'b0;
    logic [17:12]  mode = '0;
    logic [AW-1:0] sb = '0, db = '0;
    logic [AW-1:0] src_o, dst_o;
    int            checks = 0, errors = 0;
    bit            done = 0;

    always #5 clk = ~clk;

    dma_addr_hold_gen #(.AW(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start), .adv_i(adv), .mode_i(mode),
        .src_base_i(sb), .dst_base_i(db), .src_addr_o(src_o), .dst_addr_o(dst_o)
    );

    function automatic logic [17:12] mk(bit sh, int sl, bit dh, int dl);
        logic [17:12] m;
        m = '0;
        m[12] = sh; m[13] = dh;
        m[15:14] = 2'(sl); m[17:16] = 2'(dl);
        return m;
    endfunction

    function automatic logic [AW-1:0] expa(logic [AW-1:0] b, bit h, int lg, int k);
        if (h) return b + AW'(k % (1 << lg));
        return b + AW'(k);
    endfunction

    task automatic chk(string req, logic [AW-1:0] act, logic [AW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_start(logic [17:12] m, logic [AW-1:0] s, logic [AW-1:0] d);
        @(negedge clk); mode = m; sb = s; db = d; start = 1;
        @(negedge clk); start = 0;
    endtask

    task automatic do_adv();
        @(negedge clk); adv = 1;
        @(negedge clk); adv = 0;
    endtask

    // Start a run and check both sides over n advances
    task automatic run_seq(string req, bit sh, int sl, bit dh, int dl,
                           logic [AW-1:0] s, logic [AW-1:0] d, int n);
        do_start(mk(sh, sl, dh, dl), s, d);
        chk({req, " src k=0"}, src_o, s);
        chk({req, " dst k=0"}, dst_o, d);
        for (int k = 1; k <= n; k++) begin
            do_adv();
            chk({req, " src"}, src_o, expa(s, sh, sl, k));
            chk({req, " dst"}, dst_o, expa(d, dh, dl, k));
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 src reset", src_o, '0);
        chk("R1 dst reset", dst_o, '0);
    endtask

    task automatic t_idle();
        do_start(mk(0, 0, 1, 2), 32'h500, 32'h600);
        do_adv();
        repeat (3) @(negedge clk);
        chk("R9 src idle", src_o, 32'h501);
        chk("R9 dst idle", dst_o, 32'h601);
    endtask

    task automatic t_mode_change();
        do_start(mk(1, 1, 0, 0), 32'h700, 32'h800);
        mode = mk(0, 0, 1, 0);
        for (int k = 1; k <= 4; k++) begin
            do_adv();
            chk("R10 src keeps hold", src_o, expa(32'h700, 1, 1, k));
            chk("R10 dst stays linear", dst_o, expa(32'h800, 0, 0, k));
        end
    endtask

    task automatic t_start_wins();
        do_start(mk(0, 0, 0, 0), 32'h10, 32'h20);
        do_adv();
        @(negedge clk); sb = 32'h90; db = 32'hA0; start = 1; adv = 1;
        @(negedge clk); start = 0; adv = 0;
        chk("R2 start over adv src", src_o, 32'h90);
        chk("R2 start over adv dst", dst_o, 32'hA0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        run_seq("R3 linear", 0, 3, 0, 3, 32'h100, 32'h2000, 6);
        run_seq("R4 R8 src win4 unaligned", 1, 2, 0, 0, 32'h1006, 32'h3000, 9);
        run_seq("R5 R7 dst win8", 0, 0, 1, 3, 32'h4000, 32'h5003, 17);
        run_seq("R6 R7 src win2 dst win1", 1, 1, 1, 0, 32'h6001, 32'h7007, 5);
        run_seq("R6 src win1", 1, 0, 0, 0, 32'hFFFF_FFFF, 32'h0, 3);
        run_seq("R11 linear top wrap", 0, 0, 0, 0, 32'hFFFF_FFFE, 32'hFFFF_FFFF, 3);
        t_idle();
        t_mode_change();
        t_start_wins();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule